// File: doc/BRIEF.md
# Transmit Frame Descriptor Gather Sequencer

This block turns one transmit frame descriptor into an ordered series of memory read requests. A descriptor lists up to twenty buffer fragments scattered through a 36-bit address space. The sequencer issues one read request per active fragment, in list order, so that a downstream fetch engine can join the fragments into a single frame. The first request of a frame is marked as its start and the last one as its end.

The descriptor arrives as a stream of 64 little-endian 16-bit words (128 bytes) on a valid/ready input. The whole descriptor is captured before anything leaves. The count and the lengths are then checked in a single judging cycle. A descriptor that is malformed produces a one-cycle error report with a cause code and no requests. A well-formed one produces its requests on a valid/ready output. A new descriptor is taken only once the last request of the current one has been accepted.

Top module: `tfd_gather_seq`

## Requirements
- R1: While reset is held and right after it, `dw_ready` is 1 and `rq_valid` and `err_valid` are 0.
- R2: Words are numbered 0..63 in arrival order. Bits 12:8 of word 1 give the fragment count. Fragment k (0..19) takes words 2+3k (address 15:0), 3+3k (address 31:16) and 4+3k (bits 3:0 are address 35:32, bits 15:4 are the length). Word 0, bits 7:0 of word 1, and words 62 and 63 are ignored. Idle cycles on the input stream do not change the result.
- R3: After the cycle in which word 63 is accepted, exactly one cycle passes with `rq_valid`, `err_valid` and `dw_ready` all 0. In the next cycle, either the first request or the error report appears.
- R4: Requests are issued for fragments 0 up to count-1 in that order, each carrying its decoded address and length. While `rq_ready` is 0, the request and its fields hold steady.
- R5: `rq_sof` is 1 only on the first request and `rq_eof` only on the last. A single-fragment frame has both set.
- R6: A count of 0 or above 20 gives `err_code` 1, takes priority over every other check, and issues no request.
- R7: If the count is valid and any active fragment has a length above 4092, the result is `err_code` 2 with no requests. Lengths of inactive fragments are ignored.
- R8: If no earlier error applies and the lengths of the active fragments add up to more than 8192, the result is `err_code` 3 with no requests. A sum of exactly 8192 is accepted.
- R9: `err_valid` stays high for exactly one cycle, and `dw_ready` returns in the following cycle.
- R10: `dw_ready` stays 0 from the acceptance of word 63 until the last request is accepted, and rises in the cycle after that.
- R11: Bits 15:13 of word 1 (the upper bits of the count byte) do not affect the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dw_valid | input | 1 | Descriptor word valid |
| dw_ready | output | 1 | Descriptor word accepted when high with dw_valid |
| dw_data | input | 16 | Descriptor word |
| rq_valid | output | 1 | Read request valid |
| rq_ready | input | 1 | Read request accepted when high with rq_valid |
| rq_addr | output | 36 | Fragment start address |
| rq_len | output | 12 | Fragment length in bytes |
| rq_sof | output | 1 | First request of the frame |
| rq_eof | output | 1 | Last request of the frame |
| err_valid | output | 1 | One-cycle error report for a rejected descriptor |
| err_code | output | 2 | Cause: 1 bad count, 2 fragment too long, 3 frame too long |

## Verification
On every cycle, the assertions check the handshake rules: requests hold steady under back-pressure, the error pulse lasts one cycle, input and output activity never overlap, and the fixed one-cycle gap follows the final word. They also check that a frame starts with its start marker and that no issued length exceeds the fragment limit. Only the bench scenarios can show that the decoded addresses and lengths land in the right order, and that each cause code is chosen correctly at the boundaries (4092 against 4093, 8192 against 8193, count 20 against 21). The same holds for the priority among causes and for the ignored header bits and inactive entries.

// File: rtl/tfd_gather_pkg.sv
package tfd_gather_pkg;
  localparam int HW_W   = 16;   // descriptor stream word width
  localparam int ADDR_W = 36;   // fragment address width
  localparam int LEN_W  = 12;   // fragment length field width
  localparam int CNT_W  = 5;    // fragment count field width
  localparam int CNT_LO = 8;    // count position inside header word 1

  typedef struct packed {
    logic [HW_W-1:0] hn;  // address top nibble + length
    logic [HW_W-1:0] hi;  // address 31:16
    logic [HW_W-1:0] lo;  // address 15:0
  } frag_raw_t;

  typedef enum logic [1:0] {
    VERDICT_OK        = 2'd0,
    VERDICT_BAD_COUNT = 2'd1,
    VERDICT_FRAG_LONG = 2'd2,
    VERDICT_FRAME_BIG = 2'd3
  } verdict_e;

  typedef enum logic [1:0] {ST_FILL, ST_JUDGE, ST_REPORT, ST_ISSUE} seq_st_e;

  function automatic logic [ADDR_W-1:0] frag_addr(frag_raw_t f);
    return {f.hn[3:0], f.hi, f.lo};
  endfunction

  function automatic logic [LEN_W-1:0] frag_len(frag_raw_t f);
    return f.hn[HW_W-1:4];
  endfunction

  function automatic logic count_bad(logic [CNT_W-1:0] c, logic [CNT_W-1:0] lim);
    return (c == '0) || (c > lim);
  endfunction
endpackage

// File: rtl/tfd_desc_loader.sv
module tfd_desc_loader
  import tfd_gather_pkg::*;
#(
  parameter int MAX_FRAGS  = 20,
  parameter int DESC_WORDS = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fill_en,
  input  logic                           dw_valid,
  input  logic [HW_W-1:0]                dw_data,
  output logic                           load_last,
  output logic [CNT_W-1:0]               frag_cnt,
  output frag_raw_t [MAX_FRAGS-1:0]      frags
);
  localparam int HDR_WORDS = 2;
  localparam int WCNT_W    = $clog2(DESC_WORDS);
  localparam int ENT_W     = $clog2(MAX_FRAGS);
  localparam logic [WCNT_W-1:0] W_LAST  = WCNT_W'(DESC_WORDS - 1);
  localparam logic [WCNT_W-1:0] W_CNT   = WCNT_W'(1);
  localparam logic [WCNT_W-1:0] W_BODY0 = WCNT_W'(HDR_WORDS);
  localparam logic [WCNT_W-1:0] W_BODYN = WCNT_W'(HDR_WORDS + 3 * MAX_FRAGS);

  logic [WCNT_W-1:0] wcnt;
  logic [ENT_W-1:0]  ent;
  logic [1:0]        slot;
  logic              accept, in_body;

  assign accept    = fill_en && dw_valid;
  assign in_body   = (wcnt >= W_BODY0) && (wcnt < W_BODYN);
  assign load_last = accept && (wcnt == W_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt     <= '0;
      ent      <= '0;
      slot     <= '0;
      frag_cnt <= '0;
    end else if (accept) begin
      wcnt <= load_last ? '0 : wcnt + 1'b1;
      if (wcnt == W_CNT) frag_cnt <= dw_data[CNT_LO +: CNT_W];
      if (load_last) begin
        ent  <= '0;
        slot <= '0;
      end else if (in_body) begin
        if (slot == 2'd2) begin
          slot <= '0;
          ent  <= ent + 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frags <= '0;
    end else if (accept && in_body) begin
      for (int g = 0; g < MAX_FRAGS; g++) begin
        if (ent == ENT_W'(g)) begin
          case (slot)
            2'd0:    frags[g].lo <= dw_data;
            2'd1:    frags[g].hi <= dw_data;
            default: frags[g].hn <= dw_data;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tfd_verdict.sv
module tfd_verdict
  import tfd_gather_pkg::*;
#(
  parameter int MAX_FRAGS    = 20,
  parameter int FRAG_MAX_LEN = 4092,
  parameter int FRAME_MAX    = 8192
) (
  input  logic [CNT_W-1:0]                  frag_cnt,
  input  logic [MAX_FRAGS-1:0][LEN_W-1:0]   lens,
  output verdict_e                          verdict
);
  localparam int SUM_W = $clog2(MAX_FRAGS * (2 ** LEN_W) + 1);
  localparam logic [LEN_W-1:0] LEN_LIM   = LEN_W'(FRAG_MAX_LEN);
  localparam logic [SUM_W-1:0] FRAME_LIM = SUM_W'(FRAME_MAX);
  localparam logic [CNT_W-1:0] CNT_LIM   = CNT_W'(MAX_FRAGS);

  logic [MAX_FRAGS-1:0]   active, too_long;
  logic [SUM_W-1:0]       part [MAX_FRAGS];
  logic [SUM_W-1:0]       total;

  for (genvar g = 0; g < MAX_FRAGS; g++) begin : g_frag
    assign active[g]   = CNT_W'(g) < frag_cnt;
    assign too_long[g] = active[g] && (lens[g] > LEN_LIM);
    assign part[g]     = active[g] ? SUM_W'(lens[g]) : '0;
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < MAX_FRAGS; k++) total = total + part[k];
  end

  always_comb begin
    if (count_bad(frag_cnt, CNT_LIM))  verdict = VERDICT_BAD_COUNT;
    else if (|too_long)                verdict = VERDICT_FRAG_LONG;
    else if (total > FRAME_LIM)        verdict = VERDICT_FRAME_BIG;
    else                               verdict = VERDICT_OK;
  end
endmodule

// File: rtl/tfd_issue_seq.sv
module tfd_issue_seq
  import tfd_gather_pkg::*;
#(
  parameter int MAX_FRAGS = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_last,
  input  verdict_e                   verdict,
  input  logic [CNT_W-1:0]           frag_cnt,
  input  frag_raw_t [MAX_FRAGS-1:0]  frags,
  input  logic                       rq_ready,
  output logic                       fill_en,
  output logic                       rq_valid,
  output logic [ADDR_W-1:0]          rq_addr,
  output logic [LEN_W-1:0]           rq_len,
  output logic                       rq_sof,
  output logic                       rq_eof,
  output logic                       err_valid,
  output logic [1:0]                 err_code,
  output logic                       last_hs
);
  seq_st_e          st;
  logic [CNT_W-1:0] idx;
  verdict_e         err_q;
  logic             is_last;
  frag_raw_t        cur;

  assign cur     = frags[idx];
  assign is_last = idx == (frag_cnt - 1'b1);

  assign fill_en   = st == ST_FILL;
  assign rq_valid  = st == ST_ISSUE;
  assign err_valid = st == ST_REPORT;
  assign err_code  = err_q;
  assign rq_addr   = frag_addr(cur);
  assign rq_len    = frag_len(cur);
  assign rq_sof    = idx == '0;
  assign rq_eof    = is_last;
  assign last_hs   = rq_valid && rq_ready && is_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_FILL;
      idx   <= '0;
      err_q <= VERDICT_OK;
    end else begin
      case (st)
        ST_FILL:   if (load_last) st <= ST_JUDGE;
        ST_JUDGE: begin
          idx <= '0;
          if (verdict != VERDICT_OK) begin
            err_q <= verdict;
            st    <= ST_REPORT;
          end else begin
            st <= ST_ISSUE;
          end
        end
        ST_REPORT: st <= ST_FILL;
        default: begin
          if (rq_ready) begin
            if (is_last) st <= ST_FILL;
            else         idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tfd_gather_seq.sv
module tfd_gather_seq
  import tfd_gather_pkg::*;
#(
  parameter int MAX_FRAGS    = 20,
  parameter int DESC_WORDS   = 64,
  parameter int FRAG_MAX_LEN = 4092,
  parameter int FRAME_MAX    = 8192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dw_valid,
  output logic        dw_ready,
  input  logic [15:0] dw_data,
  output logic        rq_valid,
  input  logic        rq_ready,
  output logic [35:0] rq_addr,
  output logic [11:0] rq_len,
  output logic        rq_sof,
  output logic        rq_eof,
  output logic        err_valid,
  output logic [1:0]  err_code
);
  // named internal events, also observed by the bound checker
  logic                            load_last;
  logic                            last_hs;
  logic                            fill_en;
  logic [CNT_W-1:0]                frag_cnt;
  frag_raw_t [MAX_FRAGS-1:0]       frags;
  logic [MAX_FRAGS-1:0][LEN_W-1:0] frag_lens;
  verdict_e                        verdict;

  assign dw_ready = fill_en;

  for (genvar g = 0; g < MAX_FRAGS; g++) begin : g_len
    assign frag_lens[g] = frag_len(frags[g]);
  end

  tfd_desc_loader #(.MAX_FRAGS(MAX_FRAGS), .DESC_WORDS(DESC_WORDS)) u_loader (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .dw_valid(dw_valid),
    .dw_data(dw_data), .load_last(load_last), .frag_cnt(frag_cnt), .frags(frags)
  );

  tfd_verdict #(.MAX_FRAGS(MAX_FRAGS), .FRAG_MAX_LEN(FRAG_MAX_LEN),
                .FRAME_MAX(FRAME_MAX)) u_verdict (
    .frag_cnt(frag_cnt), .lens(frag_lens), .verdict(verdict)
  );

  tfd_issue_seq #(.MAX_FRAGS(MAX_FRAGS)) u_issue (
    .clk(clk), .rst_n(rst_n), .load_last(load_last), .verdict(verdict),
    .frag_cnt(frag_cnt), .frags(frags), .rq_ready(rq_ready),
    .fill_en(fill_en), .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_len(rq_len),
    .rq_sof(rq_sof), .rq_eof(rq_eof), .err_valid(err_valid),
    .err_code(err_code), .last_hs(last_hs)
  );
endmodule

// File: rtl/tfd_gather_seq_chk.sv
module tfd_gather_seq_chk #(
  parameter int FRAG_MAX_LEN = 4092
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dw_ready,
  input logic        rq_valid,
  input logic        rq_ready,
  input logic [35:0] rq_addr,
  input logic [11:0] rq_len,
  input logic        rq_sof,
  input logic        rq_eof,
  input logic        err_valid,
  input logic [1:0]  err_code,
  input logic        load_last,
  input logic        last_hs
);
  AST_GAP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_last |=> (!dw_ready && !rq_valid && !err_valid)); // R3
  AST_OUTCOME_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    load_last |=> ##1 (rq_valid || err_valid)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_addr) && $stable(rq_len)
                                 && $stable(rq_sof) && $stable(rq_eof))); // R4
  AST_FIRST_IS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq_valid) |-> rq_sof); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code != 2'd0)); // R6
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> (rq_len <= 12'(FRAG_MAX_LEN))); // R7
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> (!err_valid && dw_ready)); // R9
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    dw_ready |-> (!rq_valid && !err_valid)); // R10
  AST_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    last_hs |=> (dw_ready && !rq_valid)); // R10
endmodule

bind tfd_gather_seq tfd_gather_seq_chk #(.FRAG_MAX_LEN(FRAG_MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .dw_ready(dw_ready), .rq_valid(rq_valid),
  .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_len(rq_len), .rq_sof(rq_sof),
  .rq_eof(rq_eof), .err_valid(err_valid), .err_code(err_code),
  .load_last(load_last), .last_hs(last_hs)
);

// File: tb/tfd_gather_seq_bench.sv
module tfd_gather_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dw_valid, dw_ready;
  logic [15:0] dw_data;
  logic        rq_valid, rq_ready;
  logic [35:0] rq_addr;
  logic [11:0] rq_len;
  logic        rq_sof, rq_eof, err_valid;
  logic [1:0]  err_code;

  int checks = 0, errors = 0, cyc = 0, rdy_mode = 0;
  int obs_req, obs_code;
  logic [15:0] dsc   [64];
  logic [15:0] m_buf [64];
  int m_mode = 0, m_w = 0, m_i = 0, m_cnt = 0, m_code = 0;

  always #10 clk = ~clk;   // 50 MHz

  tfd_gather_seq u_tfd_gather_seq (
    .clk(clk), .rst_n(rst_n), .dw_valid(dw_valid), .dw_ready(dw_ready),
    .dw_data(dw_data), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_addr(rq_addr), .rq_len(rq_len), .rq_sof(rq_sof), .rq_eof(rq_eof),
    .err_valid(err_valid), .err_code(err_code)
  );

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // reference model: behavioural, updated on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_mode = 0; m_w = 0; m_i = 0;
    end else begin
      case (m_mode)
        0: if (dw_valid) begin
             m_buf[m_w] = dw_data;
             m_w++;
             if (m_w == 64) begin m_w = 0; m_mode = 1; end
           end
        1: begin
             int tot;
             tot = 0; m_code = 0;
             m_cnt = (int'(m_buf[1]) >> 8) & 31;
             if (m_cnt == 0 || m_cnt > 20) m_code = 1;
             else begin
               for (int k = 0; k < m_cnt; k++) begin
                 int l;
                 l = int'(m_buf[4 + 3*k]) >> 4;
                 if (l > 4092) m_code = 2;
                 tot += l;
               end
               if (m_code == 0 && tot > 8192) m_code = 3;
             end
             m_i = 0;
             m_mode = (m_code != 0) ? 2 : 3;
           end
        2: m_mode = 0;
        default: if (rq_ready) begin
             if (m_i == m_cnt - 1) m_mode = 0; else m_i++;
           end
      endcase
    end
  end

  // back-pressure pattern
  always @(negedge clk) rq_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check(dw_ready === (m_mode == 0), "R10 dw_ready", 64'(dw_ready), 64'(m_mode == 0));
      check(rq_valid === (m_mode == 3), "R3 rq_valid", 64'(rq_valid), 64'(m_mode == 3));
      check(err_valid === (m_mode == 2), "R9 err_valid", 64'(err_valid), 64'(m_mode == 2));
      if (m_mode == 3) begin
        logic [35:0] ea;
        ea = {m_buf[4+3*m_i][3:0], m_buf[3+3*m_i], m_buf[2+3*m_i]};
        check(rq_addr === ea, "R4 rq_addr", 64'(rq_addr), 64'(ea));
        check(rq_len === m_buf[4+3*m_i][15:4], "R4 rq_len", 64'(rq_len),
              64'(m_buf[4+3*m_i][15:4]));
        check(rq_sof === (m_i == 0), "R5 rq_sof", 64'(rq_sof), 64'(m_i == 0));
        check(rq_eof === (m_i == m_cnt - 1), "R5 rq_eof", 64'(rq_eof),
              64'(m_i == m_cnt - 1));
      end
      if (m_mode == 2)
        check(err_code === 2'(m_code), "R6 R7 R8 err_code", 64'(err_code), 64'(m_code));
      if (rq_valid && rq_ready) obs_req++;
      if (err_valid) obs_code = int'(err_code);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clear_desc(input logic [7:0] cnt_byte);
    for (int i = 0; i < 64; i++) dsc[i] = 16'hFFFF;   // inactive entries: length 4095
    dsc[1] = {cnt_byte, 8'h5A};
  endtask

  task automatic set_frag(input int k, input logic [35:0] a, input logic [11:0] l);
    dsc[2 + 3*k] = a[15:0];
    dsc[3 + 3*k] = a[31:16];
    dsc[4 + 3*k] = {l, a[35:32]};
  endtask

  task automatic send_desc(input int gap);
    for (int i = 0; i < 64; i++) begin
      bit acc;
      if (gap > 0 && (i % 7) == 3)
        repeat (gap) begin @(negedge clk); dw_valid = 1'b0; end
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        dw_valid = 1'b1;
        dw_data  = dsc[i];
        #1 acc = dw_ready;
      end
    end
  endtask

  task automatic run_desc(input string tag, input int gap, input int exp_req, input int exp_code);
    int n;
    obs_req = 0; obs_code = 0;
    send_desc(gap);
    @(negedge clk);
    dw_valid = 1'b0;
    #3;
    n = 0;
    while (!dw_ready && n < 300) begin @(negedge clk); #3; n++; end
    check(obs_req == exp_req, {tag, " request count"}, 64'(obs_req), 64'(exp_req));
    check(obs_code == exp_code, {tag, " error code"}, 64'(obs_code), 64'(exp_code));
  endtask

  initial begin
    rst_n = 1'b0; dw_valid = 1'b0; dw_data = '0;
    repeat (3) @(negedge clk);
    #3;
    check(dw_ready === 1'b1, "R1 dw_ready in reset", 64'(dw_ready), 64'd1);
    check(rq_valid === 1'b0, "R1 rq_valid in reset", 64'(rq_valid), 64'd0);
    check(err_valid === 1'b0, "R1 err_valid in reset", 64'(err_valid), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R4: three fragments, free-flowing output
    clear_desc(8'd3);
    set_frag(0, 36'h1_2345_6780, 12'd100);
    set_frag(1, 36'hA_0000_0100, 12'd200);
    set_frag(2, 36'h0_FFFF_0004, 12'd300);
    run_desc("R2 R4 three fragments", 0, 3, 0);

    // R2 idle gaps on input, R5 single fragment with back-pressure
    rdy_mode = 1;
    clear_desc(8'd1);
    set_frag(0, 36'hF_0F0F_1234, 12'd64);
    run_desc("R2 R5 single fragment", 2, 1, 0);

    // R4 full twenty-entry list, back-pressure, sum 8180
    clear_desc(8'd20);
    for (int k = 0; k < 20; k++) set_frag(k, 36'(k) * 36'h1_0001_0010, 12'd409);
    run_desc("R4 twenty fragments", 0, 20, 0);
    rdy_mode = 0;

    // R6 bad counts
    clear_desc(8'd0);
    run_desc("R6 count zero", 0, 0, 1);
    clear_desc(8'd21);
    for (int k = 0; k < 20; k++) set_frag(k, 36'h100, 12'd4);
    run_desc("R6 count 21", 0, 0, 1);
    clear_desc(8'hFF);
    run_desc("R6 count byte FF", 0, 0, 1);
    clear_desc(8'd25);
    set_frag(0, 36'h0, 12'hFFF);
    run_desc("R6 priority over length", 0, 0, 1);

    // R11 upper bits of the count byte ignored
    clear_desc(8'hE3);
    set_frag(0, 36'h5_5555_5550, 12'd1);
    set_frag(1, 36'h6_6666_6660, 12'd2);
    set_frag(2, 36'h7_7777_7770, 12'd3);
    run_desc("R11 count byte E3", 0, 3, 0);

    // R7 fragment length limit
    clear_desc(8'd2);
    set_frag(0, 36'h1000, 12'd4093);
    set_frag(1, 36'h2000, 12'd10);
    run_desc("R7 length 4093", 0, 0, 2);
    clear_desc(8'd2);
    set_frag(0, 36'h1000, 12'd10);
    set_frag(1, 36'h2000, 12'd4092);
    run_desc("R7 length 4092 inactive 4095 ignored", 0, 2, 0);
    clear_desc(8'd3);
    set_frag(0, 36'h1000, 12'd4000);
    set_frag(1, 36'h2000, 12'd4095);
    set_frag(2, 36'h3000, 12'd4000);
    run_desc("R7 priority over frame size", 0, 0, 2);

    // R8 frame size limit
    clear_desc(8'd3);
    set_frag(0, 36'h1000, 12'd4092);
    set_frag(1, 36'h3000, 12'd4092);
    set_frag(2, 36'h5000, 12'd8);
    run_desc("R8 total 8192", 0, 3, 0);
    clear_desc(8'd3);
    set_frag(0, 36'h1000, 12'd4092);
    set_frag(1, 36'h3000, 12'd4092);
    set_frag(2, 36'h5000, 12'd9);
    run_desc("R8 total 8193", 0, 0, 3);

    // R9 R10 an accepted descriptor right after an error report
    clear_desc(8'd2);
    set_frag(0, 36'h8_0000_0000, 12'd1);
    set_frag(1, 36'h9_0000_0000, 12'd2);
    rdy_mode = 1;
    run_desc("R9 R10 recovery", 1, 2, 0);
    rdy_mode = 0;

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule